// File: doc/BRIEF.md
# Averaging ADC Step Sequencer

This block is the digital controller for one programmable conversion sequencer sitting in front of an analog-to-digital converter. A trigger pulse starts a walk through a list of up to eight steps, taken back to back with no reconfiguration in between. Each step names an input channel and chooses single-ended or differential conversion, and it can request an interrupt when it completes or mark itself as the final step. For every step the controller drives the positive and negative input selects and a differential flag to the converter. It holds a request high and takes each conversion result when the converter raises a valid strobe.

An optional hardware averager sums a power-of-two number of results for the current step, from 1 up to 64. It divides the sum by a right shift and pushes one entry per step into a result FIFO whose depth equals the step capacity. Single-ended and differential steps go through the same averaging path. Errors are kept in sticky flags: a trigger that arrives while a sequence runs, a push into a full FIFO, and a pop from an empty one. All three clear only on reset.

Top module: `adc_seq_avg`

## Requirements
- R1: After a synchronous active-low reset, conv_req, irq and all three sticky flags are 0, fifo_empty is 1 and rd_data is 0.
- R2: A trigger while idle starts at step 0 and advances one step per finished entry. The walk ends after the first step whose last flag is set, or after step NSTEPS-1. conv_req stays high from the cycle after the trigger until the final result is accepted.
- R3: For a single-ended step, conv_pos equals the step's channel field and conv_neg is 0. For a differential step holding pair n in its channel field, conv_pos is 2n and conv_neg is 2n+1 (modulo 2^CH_W). conv_diff follows the step's differential flag.
- R4: avg_log is captured at the trigger. A value k makes each FIFO entry the sum of 2^k accepted results shifted right by k bits, and k=0 passes each raw result through. Values above 6 act as 6. Both conversion modes are averaged the same way.
- R5: When a step whose interrupt enable is set writes its entry, irq pulses for exactly one cycle on the next clock edge and irq_step holds that step's index. Steps without the enable produce no pulse.
- R6: A trigger that arrives while a sequence runs does not change the step order, the results or the sequence length, and it sets trig_ovr.
- R7: The FIFO returns entries oldest first. rd_data takes the new entry on the clock edge that samples fifo_rd high.
- R8: A push while the FIFO holds NSTEPS entries is dropped, the stored entries stay intact, and fifo_ovf is set.
- R9: A pop from an empty FIFO leaves rd_data at its previous value and sets fifo_udf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Start pulse for a sequence |
| step_chan | input | NSTEPS*CH_W | Channel field per step, step i at bits i*CH_W |
| step_diff | input | NSTEPS | Differential mode flag per step |
| step_ie | input | NSTEPS | Interrupt enable per step |
| step_last | input | NSTEPS | Last-step flag per step |
| avg_log | input | 3 | log2 of the averaging count |
| conv_req | output | 1 | Conversion request, high while a sequence runs |
| conv_pos | output | CH_W | Positive input select |
| conv_neg | output | CH_W | Negative input select |
| conv_diff | output | 1 | Differential conversion flag |
| conv_valid | input | 1 | Result strobe from the converter |
| conv_data | input | DATA_W | Conversion result |
| irq | output | 1 | Step completion pulse |
| irq_step | output | STEP_W | Index of the step that completed |
| fifo_rd | input | 1 | FIFO pop |
| rd_data | output | DATA_W | Popped FIFO entry |
| fifo_empty | output | 1 | FIFO holds no entries |
| trig_ovr | output | 1 | Sticky flag for a trigger while busy |
| fifo_ovf | output | 1 | Sticky flag for a push into a full FIFO |
| fifo_udf | output | 1 | Sticky flag for a pop from an empty FIFO |

## Verification
The step walker is exercised with a full eight-step list of mixed modes without averaging, with short lists ended early by a last flag, and with randomly drawn lists and averaging factors. Together these separate errors in step order, in the end condition and in the channel mapping for each mode. The converter model gaps its valid strobe at random, so a result counted twice or a sample count that ignores the strobe changes the FIFO contents. The averaging setting of 7 separates a clamped averager from one that uses the raw field. Directed runs then aim a trigger into a busy sequence, fill the FIFO twice without reading, and pop it empty.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants and helpers for the averaging step sequencer.
// Assumes averaging is limited to 2^6 samples per entry.
package adc_seq_pkg;

    localparam int AVG_LOG_MAX = 6;

    // Index width that stays at least one bit for single-entry structures.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Limit the averaging exponent to the supported maximum.
    function automatic logic [2:0] clamp_avg(input logic [2:0] v);
        return (v > 3'(AVG_LOG_MAX)) ? 3'(AVG_LOG_MAX) : v;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
// Module: step walker and accumulator. On a trigger while idle it runs the
// configured steps in order, drives the converter input selects, sums 2^k
// results per step and emits one push per step. Assumes conv_valid is only
// meaningful while conv_req is high and that CH_W is at least 2.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NSTEPS = 8,
    parameter int CH_W   = 5,
    parameter int DATA_W = 12,
    localparam int STEP_W = idx_w(NSTEPS),
    localparam int ACC_W  = DATA_W + AVG_LOG_MAX
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig,
    input  logic [NSTEPS*CH_W-1:0]   step_chan,
    input  logic [NSTEPS-1:0]        step_diff,
    input  logic [NSTEPS-1:0]        step_ie,
    input  logic [NSTEPS-1:0]        step_last,
    input  logic [2:0]               avg_log,
    input  logic                     conv_valid,
    input  logic [DATA_W-1:0]        conv_data,
    output logic                     conv_req,
    output logic [CH_W-1:0]          conv_pos,
    output logic [CH_W-1:0]          conv_neg,
    output logic                     conv_diff,
    output logic                     push,
    output logic [DATA_W-1:0]        push_data,
    output logic                     irq,
    output logic [STEP_W-1:0]        irq_step,
    output logic                     trig_ovr
);

    logic              busy_q;
    logic [STEP_W-1:0] step_q;
    logic [5:0]        cnt_q;
    logic [2:0]        avg_q;
    logic [ACC_W-1:0]  acc_q;
    logic              irq_q;
    logic [STEP_W-1:0] irq_step_q;
    logic              ovr_q;

    logic [CH_W-1:0]   chan_a [NSTEPS];
    logic [CH_W-1:0]   cur_chan;
    logic              cur_diff;
    logic              accept;
    logic              last_sample;
    logic              end_step;
    logic [5:0]        cnt_tgt;
    logic [ACC_W-1:0]  sum_next;
    logic [ACC_W-1:0]  shifted;

    // Split the packed channel bus into one field per step.
    for (genvar g = 0; g < NSTEPS; g++) begin : g_chan
        assign chan_a[g] = step_chan[g*CH_W +: CH_W];
    end

    // Decode the current step and the averaging state.
    always_comb begin
        cur_chan    = chan_a[step_q];
        cur_diff    = step_diff[step_q];
        accept      = busy_q & conv_valid;
        cnt_tgt     = 6'((7'd1 << avg_q) - 7'd1);
        last_sample = (cnt_q == cnt_tgt);
        end_step    = step_last[step_q] | (step_q == STEP_W'(NSTEPS - 1));
        sum_next    = acc_q + ACC_W'(conv_data);
        shifted     = sum_next >> avg_q;
    end

    // Map the step's channel field onto the converter input selects.
    always_comb begin
        if (cur_diff) begin
            conv_pos = {cur_chan[CH_W-2:0], 1'b0};
            conv_neg = {cur_chan[CH_W-2:0], 1'b1};
        end else begin
            conv_pos = cur_chan;
            conv_neg = '0;
        end
    end

    assign conv_req  = busy_q;
    assign conv_diff = cur_diff;
    assign push      = accept & last_sample;
    assign push_data = shifted[DATA_W-1:0];
    assign irq       = irq_q;
    assign irq_step  = irq_step_q;
    assign trig_ovr  = ovr_q;

    // Sequence state: start, accumulate, advance and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= '0;
            cnt_q  <= '0;
            avg_q  <= '0;
            acc_q  <= '0;
        end else if (trig && !busy_q) begin
            busy_q <= 1'b1;
            step_q <= '0;
            cnt_q  <= '0;
            acc_q  <= '0;
            avg_q  <= clamp_avg(avg_log);
        end else if (accept) begin
            if (last_sample) begin
                cnt_q <= '0;
                acc_q <= '0;
                if (end_step) busy_q <= 1'b0;
                else          step_q <= step_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                acc_q <= sum_next;
            end
        end
    end

    // Completion pulse and its step index, one cycle after the push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q      <= 1'b0;
            irq_step_q <= '0;
        end else begin
            irq_q      <= push & step_ie[step_q];
            irq_step_q <= step_q;
        end
    end

    // Sticky flag for a trigger that lands on a running sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovr_q <= 1'b0;
        else if (trig && busy_q) ovr_q <= 1'b1;
    end

    // R6: a trigger while busy neither restarts nor moves the walk.
    a_r6_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && trig && !conv_valid) |=> (busy_q && $stable(step_q) && $stable(cnt_q)));

    // R4: the sample counter never passes the averaging target.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= cnt_tgt));

    // R2: a sequence that finishes leaves the request low afterwards.
    a_r2_end_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (push && end_step && !trig) |=> !conv_req);

endmodule

// File: rtl/adc_seq_fifo.sv
// Module: result FIFO with registered read data. Pushes into a full FIFO
// are dropped and pops from an empty FIFO hold the last read value; both
// set sticky flags cleared only by reset. Assumes DEPTH is at least 1.
module adc_seq_fifo
    import adc_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 12,
    localparam int PTR_W = idx_w(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         rd,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         ovf,
    output logic         udf
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     rd_q;
    logic             ovf_q;
    logic             udf_q;
    logic             full;
    logic             wr_ok;
    logic             rd_ok;

    // Occupancy decode and accepted operations.
    always_comb begin
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_W'(DEPTH));
        wr_ok = wr & !full;
        rd_ok = rd & !empty;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr_q] <= wr_data;
    end

    // Pointers, occupancy and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            rd_q   <= '0;
        end else begin
            if (wr_ok) wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (rd_ok) begin
                rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
                rd_q   <= mem[rptr_q];
            end
            if (wr_ok && !rd_ok)      cnt_q <= cnt_q + 1'b1;
            else if (rd_ok && !wr_ok) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (wr && full)  ovf_q <= 1'b1;
            if (rd && empty) udf_q <= 1'b1;
        end
    end

    assign rd_data = rd_q;
    assign ovf     = ovf_q;
    assign udf     = udf_q;

    // R8: occupancy never exceeds the depth.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R8: a push into a full FIFO leaves the occupancy and raises the flag.
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !rd) |=> ($stable(cnt_q) && ovf_q));

    // R9: a pop from an empty FIFO holds the read data.
    a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && empty) |=> ($stable(rd_data) && udf_q));

endmodule

// File: rtl/adc_seq_avg.sv
// Module: top of the averaging step sequencer. Joins the step walker to
// the result FIFO; step capacity and FIFO depth share NSTEPS.
// Assumes NSTEPS is 1, 4 or 8 and CH_W is at least 2.
module adc_seq_avg
    import adc_seq_pkg::*;
#(
    parameter int NSTEPS = 8,
    parameter int CH_W   = 5,
    parameter int DATA_W = 12,
    localparam int STEP_W = idx_w(NSTEPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig,
    input  logic [NSTEPS*CH_W-1:0] step_chan,
    input  logic [NSTEPS-1:0]      step_diff,
    input  logic [NSTEPS-1:0]      step_ie,
    input  logic [NSTEPS-1:0]      step_last,
    input  logic [2:0]             avg_log,
    output logic                   conv_req,
    output logic [CH_W-1:0]        conv_pos,
    output logic [CH_W-1:0]        conv_neg,
    output logic                   conv_diff,
    input  logic                   conv_valid,
    input  logic [DATA_W-1:0]      conv_data,
    output logic                   irq,
    output logic [STEP_W-1:0]      irq_step,
    input  logic                   fifo_rd,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   fifo_empty,
    output logic                   trig_ovr,
    output logic                   fifo_ovf,
    output logic                   fifo_udf
);

    logic              push;
    logic [DATA_W-1:0] push_data;

    adc_seq_ctrl #(.NSTEPS(NSTEPS), .CH_W(CH_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .step_chan(step_chan), .step_diff(step_diff), .step_ie(step_ie),
        .step_last(step_last), .avg_log(avg_log),
        .conv_valid(conv_valid), .conv_data(conv_data),
        .conv_req(conv_req), .conv_pos(conv_pos), .conv_neg(conv_neg),
        .conv_diff(conv_diff), .push(push), .push_data(push_data),
        .irq(irq), .irq_step(irq_step), .trig_ovr(trig_ovr)
    );

    adc_seq_fifo #(.DEPTH(NSTEPS), .W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr(push), .wr_data(push_data),
        .rd(fifo_rd), .rd_data(rd_data), .empty(fifo_empty),
        .ovf(fifo_ovf), .udf(fifo_udf)
    );

    // R5: every completion pulse follows a push on the previous edge.
    a_r5_irq_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(push));

    // R7: a push always leaves the FIFO non-empty on the next cycle.
    a_r7_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !fifo_rd) |=> !fifo_empty);

endmodule

// File: tb/test_adc_seq_avg.sv
module test_adc_seq_avg;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 8;
    localparam int CW  = 5;
    localparam int DW  = 12;
    localparam int SW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trig = 1'b0;
    logic [NS*CW-1:0] step_chan = '0;
    logic [NS-1:0]   step_diff = '0, step_ie = '0, step_last = '0;
    logic [2:0]      avg_log = '0;
    logic            conv_req, conv_diff, conv_valid = 1'b0;
    logic [CW-1:0]   conv_pos, conv_neg;
    logic [DW-1:0]   conv_data = '0;
    logic            irq, fifo_rd = 1'b0, fifo_empty;
    logic [SW-1:0]   irq_step;
    logic [DW-1:0]   rd_data;
    logic            trig_ovr, fifo_ovf, fifo_udf;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_avg #(.NSTEPS(NS), .CH_W(CW), .DATA_W(DW)) i_adc_seq_avg (
        .clk(clk), .rst_n(rst_n), .trig(trig), .step_chan(step_chan),
        .step_diff(step_diff), .step_ie(step_ie), .step_last(step_last),
        .avg_log(avg_log), .conv_req(conv_req), .conv_pos(conv_pos),
        .conv_neg(conv_neg), .conv_diff(conv_diff), .conv_valid(conv_valid),
        .conv_data(conv_data), .irq(irq), .irq_step(irq_step),
        .fifo_rd(fifo_rd), .rd_data(rd_data), .fifo_empty(fifo_empty),
        .trig_ovr(trig_ovr), .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_avg(input logic [2:0] v);
        return (v > 3'd6) ? 6 : int'(v);
    endfunction

    function automatic logic [CW-1:0] exp_pos(input int s);
        logic [CW-1:0] c = step_chan[s*CW +: CW];
        return step_diff[s] ? {c[CW-2:0], 1'b0} : c;
    endfunction

    function automatic logic [CW-1:0] exp_neg(input int s);
        logic [CW-1:0] c = step_chan[s*CW +: CW];
        return step_diff[s] ? {c[CW-2:0], 1'b1} : '0;
    endfunction

    // Trigger a sequence and act as the converter; optionally re-trigger
    // at iteration trig_at while busy. Expected FIFO entries are queued.
    task automatic run_seq(input int trig_at);
        int si = 0, cnt = 0, av = eff_avg(avg_log), exp_steps = 0, got_steps = 0;
        int sum = 0;
        bit pend = 0;
        int pstep = 0;
        bit done = 0;
        for (int s = 0; s < NS; s++) begin
            exp_steps++;
            if (step_last[s]) break;
        end
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        check(conv_req == 1'b1, "R2 request after trigger", int'(conv_req), 1);
        for (int it = 0; it < 20000; it++) begin
            check(irq == pend, "R5 irq pulse", int'(irq), int'(pend));
            if (pend) check(int'(irq_step) == pstep, "R5 irq step", int'(irq_step), pstep);
            pend = 0;
            conv_valid = 1'b0;
            trig = (it == trig_at);
            if (!conv_req) begin
                trig = 1'b0;
                break;
            end
            check(!done, "R2 request drops after last step", int'(conv_req), 0);
            check(conv_pos == exp_pos(si), "R3 positive select", int'(conv_pos), int'(exp_pos(si)));
            check(conv_neg == exp_neg(si), "R3 negative select", int'(conv_neg), int'(exp_neg(si)));
            check(conv_diff == step_diff[si], "R3 mode flag", int'(conv_diff), int'(step_diff[si]));
            if (!done && ($urandom % 4) != 0) begin
                logic [DW-1:0] d = DW'($urandom);
                conv_valid = 1'b1;
                conv_data = d;
                sum += int'(d);
                cnt++;
                if (cnt == (1 << av)) begin
                    exp_q.push_back(DW'(sum >> av));
                    pend = step_ie[si];
                    pstep = si;
                    sum = 0;
                    cnt = 0;
                    got_steps++;
                    if (step_last[si] || si == NS - 1) done = 1;
                    else si++;
                end
            end
            @(negedge clk);
        end
        conv_valid = 1'b0;
        trig = 1'b0;
        check(got_steps == exp_steps, "R2 sequence length", got_steps, exp_steps);
    endtask

    task automatic pop(output logic [DW-1:0] v);
        @(negedge clk) fifo_rd = 1'b1;
        @(negedge clk) fifo_rd = 1'b0;
        v = rd_data;
    endtask

    task automatic drain(input string req);
        logic [DW-1:0] v;
        while (exp_q.size() > 0) begin
            logic [DW-1:0] e = exp_q.pop_front();
            pop(v);
            check(v == e, req, int'(v), int'(e));
            last_rd = v;
        end
        check(fifo_empty == 1'b1, "R7 empty after drain", int'(fifo_empty), 1);
    endtask

    task automatic set_all(input logic [NS-1:0] diff, input logic [NS-1:0] ie,
                           input logic [NS-1:0] last, input logic [2:0] av);
        for (int s = 0; s < NS; s++) step_chan[s*CW +: CW] = CW'($urandom);
        step_diff = diff;
        step_ie = ie;
        step_last = last;
        avg_log = av;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                tests++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(conv_req == 0, "R1 request idle", int'(conv_req), 0);
        check(irq == 0, "R1 irq idle", int'(irq), 0);
        check(fifo_empty == 1, "R1 fifo empty", int'(fifo_empty), 1);
        check(rd_data == 0, "R1 read data", int'(rd_data), 0);
        check({trig_ovr, fifo_ovf, fifo_udf} == 3'b000, "R1 flags clear",
              int'({trig_ovr, fifo_ovf, fifo_udf}), 0);

        // R2 R3 R7: full eight-step list, raw results, mixed modes
        set_all(8'b1010_0110, 8'hFF, 8'h00, 3'd0);
        run_seq(-1);
        drain("R7 raw entry order");

        // R4 R5: four-sample averaging, list ended by a last flag at step 3
        set_all(8'b0000_0101, 8'b0000_1010, 8'b0000_1000, 3'd2);
        run_seq(-1);
        drain("R4 average of four");

        // R2: single step ended at step 0
        set_all(8'b0000_0001, 8'h01, 8'h01, 3'd1);
        run_seq(-1);
        drain("R2 single step entry");

        // R4: field value 7 acts as 64 samples
        set_all(8'b0000_0010, 8'h03, 8'b0000_0010, 3'd7);
        run_seq(-1);
        drain("R4 clamped averaging");

        check(trig_ovr == 0, "R6 flag clear before overrun", int'(trig_ovr), 0);

        // Random lists and averaging factors
        for (int r = 0; r < 20; r++) begin
            set_all(NS'($urandom), NS'($urandom), NS'($urandom), 3'($urandom % 4));
            run_seq(-1);
            drain("R4 random list entry");
        end

        // R6: trigger during a running sequence
        set_all(8'b0011_0000, 8'hFF, 8'b0010_0000, 3'd1);
        run_seq(3);
        check(trig_ovr == 1, "R6 overrun flag", int'(trig_ovr), 1);
        drain("R6 results unchanged by retrigger");

        // R8: two full sequences without reading
        check(fifo_ovf == 0, "R8 flag clear before overflow", int'(fifo_ovf), 0);
        set_all(8'h0F, 8'h00, 8'h00, 3'd0);
        run_seq(-1);
        run_seq(-1);
        for (int k = 0; k < NS; k++) void'(exp_q.pop_back());
        check(fifo_ovf == 1, "R8 overflow flag", int'(fifo_ovf), 1);
        drain("R8 stored entries intact");

        // R9: pop from empty FIFO
        check(fifo_udf == 0, "R9 flag clear before underflow", int'(fifo_udf), 0);
        pop(v);
        check(v == last_rd, "R9 read data held", int'(v), int'(last_rd));
        check(fifo_udf == 1, "R9 underflow flag", int'(fifo_udf), 1);

        // R1: reset clears sticky flags
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check({trig_ovr, fifo_ovf, fifo_udf} == 3'b000, "R1 flags after reset",
              int'({trig_ovr, fifo_ovf, fifo_udf}), 0);
        check(rd_data == 0, "R1 read data after reset", int'(rd_data), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule